// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

A parameterised bank of general-purpose pins, 16 by default, that software controls through a small word-addressed register window. Each pin is either an input or an output, under a per-pin direction bit. Output pins drive a stored output value. Input pins are brought into the clock domain and watched for one chosen transition per pin: rising or falling, set by a one-bit polarity field. A detected transition on an unmasked input pin latches a sticky pending bit. Software clears pending bits by writing ones to them. One interrupt line stays high while any pending bit is set.

Software reads the synchronised input levels through a per-pin enable mask, and it can read back every control register. The byte address selects a 32-bit word, and bits [1:0] are not used. The word offsets are: 0x00 input levels (read-only), 0x04 output values, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 pending status, and 0x18 input-read enable. Each register is N bits wide. Reads return their data one cycle after the read strobe.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output, direction, polarity, mask and input-read-enable registers read all ones, the pending register and input levels read zero, and irq is low.
- R2: A direction bit of 1 makes the pin an input (pin_oe low, pin_out low). A direction bit of 0 sets pin_oe high and drives the stored output bit on pin_out. This takes effect in the cycle after the write to the direction or output register.
- R3: A polarity bit of 1 detects rising transitions on that pin and a polarity bit of 0 detects falling transitions. The other transition is ignored.
- R4: A transition sets a pending bit only when the pin's direction bit is 1 and its mask bit is 0. A mask bit of 1, or an output pin, suppresses the event.
- R5: Writing the pending offset clears exactly the bits written as 1, and bits written as 0 keep their value. A transition detected in the same cycle as the clear leaves its bit set.
- R6: irq is high exactly while at least one pending bit is set, and it updates on the same clock edge as the pending register.
- R7: Reading offset 0x00 returns the synchronised input levels ANDed with the input-read-enable register.
- R8: Writes to offset 0x00 change no register.
- R9: Reads of unmapped offsets (0x1C and above) return zero, and writes to them change no register.
- R10: Inputs pass through two synchronising flops plus a history flop. A pending bit becomes visible on the third rising clock edge after the pin changes.
- R11: The output, direction, polarity, mask and input-read-enable registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | N | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | N | Read data, valid the cycle after bus_rd |
| pin_in | input | N | Asynchronous pin levels |
| pin_out | output | N | Output values for driven pins |
| pin_oe | output | N | Per-pin output enable |
| irq | output | 1 | High while any pending bit is set |

## Verification
The assertions assume that each pin changes level at most once every three clock cycles. Under that assumption a transition is seen by the history flop before the next one arrives. The bench therefore holds every new pin pattern for at least three cycles before it changes pins again. The assertions also assume that strobes are applied only after reset is released. The bench drives all bus and pin inputs on falling edges and keeps each strobe high for exactly one cycle, so every write is taken by exactly one rising edge. The same-cycle clear-versus-detect case is reached by placing the clearing write on the rising edge on which the transition is due to land.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // word offsets (byte address >> 2) seen by software
  localparam int unsigned WORD_LEVEL  = 0;
  localparam int unsigned WORD_OUTVAL = 1;
  localparam int unsigned WORD_DIR    = 2;
  localparam int unsigned WORD_POL    = 3;
  localparam int unsigned WORD_MASK   = 4;
  localparam int unsigned WORD_PEND   = 5;
  localparam int unsigned WORD_RDEN   = 6;

  typedef enum logic [2:0] {
    SEL_LEVEL  = 3'd0,
    SEL_OUTVAL = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_POL    = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_PEND   = 3'd5,
    SEL_RDEN   = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input int unsigned word);
    case (word)
      WORD_LEVEL:  return SEL_LEVEL;
      WORD_OUTVAL: return SEL_OUTVAL;
      WORD_DIR:    return SEL_DIR;
      WORD_POL:    return SEL_POL;
      WORD_MASK:   return SEL_MASK;
      WORD_PEND:   return SEL_PEND;
      WORD_RDEN:   return SEL_RDEN;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int N           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] dir_in,
  input  logic [N-1:0] pol_rise,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] level,
  output logic [N-1:0] event_hit
);
  logic [N-1:0] sync_lvl;
  logic [N-1:0] hist_q;

  gpio_sync_chain #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (sync_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= sync_lvl;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic went_up, went_down, chosen;
      always_comb begin
        went_up      = sync_lvl[i] & ~hist_q[i];
        went_down    = ~sync_lvl[i] & hist_q[i];
        chosen       = pol_rise[i] ? went_up : went_down;
        event_hit[i] = chosen & dir_in[i] & ~mask_in[i];
      end
    end
  endgenerate

  assign level = sync_lvl;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [N-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  level,
  input  logic [N-1:0]  event_hit,
  output logic [N-1:0]  outval_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  pol_q,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  rden_q,
  output logic          irq_q
);
  localparam int WAW = AW - 2;

  logic [WAW-1:0] word;
  reg_sel_e       sel;
  logic [N-1:0]   pend_d;
  logic [N-1:0]   rd_mux;
  logic           wr_pend;

  assign word    = bus_addr[AW-1:2];
  assign sel     = decode_word(int'(word));
  assign wr_pend = bus_wr && (sel == SEL_PEND);

  // pending: clear by ones, new events win over a clear
  always_comb begin
    pend_d = pend_q;
    if (wr_pend) pend_d = pend_d & ~bus_wdata;
    pend_d = pend_d | event_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outval_q <= '1;
      dir_q    <= '1;
      pol_q    <= '1;
      mask_q   <= '1;
      rden_q   <= '1;
      pend_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
      if (bus_wr) begin
        case (sel)
          SEL_OUTVAL: outval_q <= bus_wdata;
          SEL_DIR:    dir_q    <= bus_wdata;
          SEL_POL:    pol_q    <= bus_wdata;
          SEL_MASK:   mask_q   <= bus_wdata;
          SEL_RDEN:   rden_q   <= bus_wdata;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_LEVEL:  rd_mux = level & rden_q;
      SEL_OUTVAL: rd_mux = outval_q;
      SEL_DIR:    rd_mux = dir_q;
      SEL_POL:    rd_mux = pol_q;
      SEL_MASK:   rd_mux = mask_q;
      SEL_PEND:   rd_mux = pend_q;
      SEL_RDEN:   rd_mux = rden_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N = 16
) (
  input  logic [N-1:0] outval,
  input  logic [N-1:0] dir_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_pad
      assign pin_oe[i]  = ~dir_in[i];
      assign pin_out[i] = outval[i] & ~dir_in[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int N           = 16,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [N-1:0]  bus_wdata,
  input  logic          bus_rd,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  logic [N-1:0] level_w, event_w;
  logic [N-1:0] outval_w, dir_w, pol_w, mask_w, pend_w, rden_w;

  gpio_edge_detect #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .dir_in    (dir_w),
    .pol_rise  (pol_w),
    .mask_in   (mask_w),
    .level     (level_w),
    .event_hit (event_w)
  );

  gpio_port_regs #(.N(N), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .level     (level_w),
    .event_hit (event_w),
    .outval_q  (outval_w),
    .dir_q     (dir_w),
    .pol_q     (pol_w),
    .mask_q    (mask_w),
    .pend_q    (pend_w),
    .rden_q    (rden_w),
    .irq_q     (irq)
  );

  gpio_pad_drive #(.N(N)) u_pad (
    .outval  (outval_w),
    .dir_in  (dir_w),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int N  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  dir
);
  localparam int WAW = AW - 2;
  logic [WAW-1:0] word;
  assign word = bus_addr[AW-1:2];

  AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0)); // R6

  AST_MASKED_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & ~$past(pend) & $past(mask)) == '0)); // R4

  AST_OUTPUT_PIN_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & ~$past(pend) & ~$past(dir)) == '0)); // R4

  AST_CLEAR_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && $past(word) == WAW'(5) && $past(mask) == '1 && !$past(rst))
      |-> ((pend & $past(bus_wdata)) == '0)); // R5

  AST_PADS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr) && !$past(rst)) |-> ($stable(pin_out) && $stable(pin_oe))); // R2
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.N(N), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .pend      (pend_w),
  .mask      (mask_w),
  .dir       (dir_w)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  localparam int N  = 16;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_LVL = 8'h00, A_OUT = 8'h04, A_DIR = 8'h08,
    A_POL = 8'h0C, A_MSK = 8'h10, A_PND = 8'h14, A_REN = 8'h18,
    A_GAP = 8'h1C, A_FAR = 8'h40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int compared = 0;
  int mismatched = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_port #(.N(N), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  // monitor: compare read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (bus_rdata !== e) begin
        mismatched++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  // all tasks are entered on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [N-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input logic [N-1:0] got, input logic [N-1:0] e, input string t);
    compared++;
    if (got !== e) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  task automatic pins(input logic [N-1:0] v);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({15'b0, irq}, '0, "R1 irq");
    chk(pin_oe, '0, "R1/R2 pin_oe");
    chk(pin_out, '0, "R1/R2 pin_out");
    rd(A_OUT, 16'hFFFF, "R1 out");
    rd(A_DIR, 16'hFFFF, "R1 dir");
    rd(A_POL, 16'hFFFF, "R1 pol");
    rd(A_MSK, 16'hFFFF, "R1 mask");
    rd(A_REN, 16'hFFFF, "R1 rden");
    rd(A_PND, 16'h0000, "R1 pend");
    rd(A_LVL, 16'h0000, "R1 level");

    // R3 polarity: low byte rising, high byte falling
    wr(A_MSK, 16'h0000);
    wr(A_POL, 16'h00FF);
    rd(A_POL, 16'h00FF, "R11 pol");
    pin_in = 16'h0101;
    repeat (2) @(negedge clk);
    rd(A_PND, 16'h0000, "R10 not yet after two edges");
    // third edge happened during the read; check irq
    chk({15'b0, irq}, 16'h0001, "R6 irq set");
    rd(A_PND, 16'h0001, "R3 rising only on rise pin");
    pins(16'h0000);
    rd(A_PND, 16'h0101, "R3 falling pin sets");

    // R5 clear by ones
    wr(A_PND, 16'h0000);
    rd(A_PND, 16'h0101, "R5 zeros keep");
    wr(A_PND, 16'h0001);
    chk({15'b0, irq}, 16'h0001, "R6 irq stays");
    rd(A_PND, 16'h0100, "R5 partial clear");
    wr(A_PND, 16'h0100);
    chk({15'b0, irq}, 16'h0000, "R6 irq drops");

    // R4 mask and direction suppress
    wr(A_MSK, 16'h0002);
    pins(16'h0002);
    rd(A_PND, 16'h0000, "R4 masked pin");
    wr(A_DIR, 16'hFFFB);
    chk(pin_oe, 16'h0004, "R2 oe after dir write");
    chk(pin_out, 16'h0004, "R2 drives stored one");
    pins(16'h0006);
    rd(A_PND, 16'h0000, "R4 output pin");

    // R2 / R11 output drive
    wr(A_OUT, 16'hA5A5);
    wr(A_DIR, 16'h0F0F);
    chk(pin_oe, 16'hF0F0, "R2 oe pattern");
    chk(pin_out, 16'hA0A0, "R2 out pattern");
    rd(A_OUT, 16'hA5A5, "R11 out");
    rd(A_DIR, 16'h0F0F, "R11 dir");
    rd(A_MSK, 16'h0002, "R11 mask");

    // R7 / R8 input read gating
    wr(A_REN, 16'h00FF);
    pins(16'h1234);
    rd(A_LVL, 16'h0034, "R7 gated level");
    rd(A_PND, 16'h0000, "R3 wrong-way edges ignored");
    wr(A_LVL, 16'h0000);
    rd(A_LVL, 16'h0034, "R8 level unchanged");
    rd(A_REN, 16'h00FF, "R8 rden unchanged");
    rd(A_OUT, 16'hA5A5, "R8 out unchanged");

    // R9 unmapped
    rd(A_GAP, 16'h0000, "R9 read gap");
    rd(A_FAR, 16'h0000, "R9 read far");
    wr(A_GAP, 16'hFFFF);
    wr(A_FAR, 16'hFFFF);
    rd(A_OUT, 16'hA5A5, "R9 out unchanged");
    rd(A_DIR, 16'h0F0F, "R9 dir unchanged");
    rd(A_POL, 16'h00FF, "R9 pol unchanged");
    rd(A_MSK, 16'h0002, "R9 mask unchanged");
    rd(A_PND, 16'h0000, "R9 pend unchanged");
    chk(pin_out, 16'hA0A0, "R9 pins unchanged");

    // R5 event wins over same-cycle clear
    wr(A_MSK, 16'hFFFF);
    wr(A_DIR, 16'hFFFF);
    pins(16'h0000);
    wr(A_PND, 16'hFFFF);
    wr(A_POL, 16'hFFFF);
    wr(A_MSK, 16'h0000);
    pins(16'h0008);
    rd(A_PND, 16'h0008, "R10 third edge set");
    pin_in = 16'h0009;
    repeat (2) @(negedge clk);
    wr(A_PND, 16'hFFFF);
    rd(A_PND, 16'h0001, "R5 event beats clear");
    chk({15'b0, irq}, 16'h0001, "R6 irq after race");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R1: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule